// File: doc/BRIEF.md
# Nibble-Multiplexed ADC Output Port

This block takes finished pixel results from an ADC, either 10 or 12 bits wide depending on a parameter, and sends each one out over a shared 6-bit data bus. Each result takes four master-clock phases. The upper half of the word is on the bus for the first two phases and the lower half for the last two. The bus pins are shared with a configuration input path. Whenever the line-start control is high, the port stops driving all six pins so that the pins can carry configuration input.

A result is offered with a one-cycle valid strobe. The port keeps it in a pending slot until the current four-phase sequence has finished, then loads it into the output holding register at the start of phase 0. A result that arrives early therefore never disturbs the word being sent. Strobing one result every four cycles gives a sequence with no gaps. When no new result is pending, the bus stays on phase 0 of the last word.

Top module: `adc_nibble_port`

## Requirements
- R1: While reset is asserted, the output enable of all six pins is 0 and the phase counter is at phase 0.
- R2: A loaded result occupies four consecutive phases, 0, 1, 2, 3. The bus value is identical in phases 0 and 1 and identical in phases 2 and 3.
- R3: With RES_BITS=12, phases 0 and 1 put result bits 11..6 on bus bits 5..0, and phases 2 and 3 put result bits 5..0 on bus bits 5..0.
- R4: With RES_BITS=10, phases 0 and 1 put result bits 9..4 on bus bits 5..0. Phases 2 and 3 put result bits 3..0 on bus bits 5..2, and bus bits 1..0 are 0.
- R5: The output enable is registered. After any clock edge at which line-start is sampled high, all six enables are 0. After an edge at which it is sampled low, all six are 1.
- R6: Take a valid strobe sampled at edge k while the port is idle. Phase 0 of that result is on the bus after edge k+1.
- R7: A result strobed while a sequence is in phases 0 to 2 leaves the current result unchanged for all four phases. The new result starts at phase 0 on the edge after phase 3.
- R8: Results strobed once every four cycles are sent back to back, with no idle phase between them.
- R9: A line-start high aborts any sequence, discards any pending result, and ignores valid strobes. After line-start falls, the phase is 0 and the bus shows the upper half of the last loaded result.
- R10: With no pending result, the port idles at phase 0 and keeps driving the upper half of the last loaded result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_start_i | input | 1 | Line-start control; high releases the bus |
| res_valid_i | input | 1 | One-cycle strobe marking a new result |
| res_data_i | input | RES_BITS | ADC result word |
| bus_o | output | 6 | Value for the data bus pins |
| bus_oe_o | output | 6 | Per-pin output enable, 1 = drive |

## Verification
The hardest case to reach is a result strobed in the middle of a running sequence. The stimulus must hit phases 0 to 2 exactly, and the early word must then appear exactly one edge after phase 3. The bench counts edges from a known load and places the second strobe on the phase-0 cycle. It then checks all four phases of the first word and the first phase of the second. A near-exhaustive streaming sweep runs every 12-bit value back to back through both width variants at once. A line-start pulse is applied mid-sequence with a strobe under it, to show the strobe is discarded.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
  localparam int unsigned BUS_W = 6;
  localparam int unsigned PH_W  = 2;
  typedef logic [PH_W-1:0] phase_t;
  localparam phase_t PH_LAST = phase_t'(2**PH_W - 1);
endpackage

// File: rtl/adc_port_phase_seq.sv
module adc_port_phase_seq
  import adc_port_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   line_start_i,
  input  logic   pend_v_i,
  output phase_t phase_o,
  output logic   busy_o,
  output logic   load_o
);
  phase_t phase_q;
  logic   busy_q;
  logic   seq_done;

  assign seq_done = !busy_q || (phase_q == PH_LAST);
  assign load_o   = !line_start_i && pend_v_i && seq_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      busy_q  <= 1'b0;
    end else if (line_start_i) begin
      phase_q <= '0;
      busy_q  <= 1'b0;
    end else if (seq_done) begin
      phase_q <= '0;
      busy_q  <= pend_v_i;
    end else begin
      phase_q <= phase_q + phase_t'(1);
    end
  end

  assign phase_o = phase_q;
  assign busy_o  = busy_q;
endmodule

// File: rtl/adc_port_result_hold.sv
module adc_port_result_hold #(
  parameter int unsigned RES_BITS = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                line_start_i,
  input  logic                res_valid_i,
  input  logic [RES_BITS-1:0] res_data_i,
  input  logic                load_i,
  output logic                pend_v_o,
  output logic [RES_BITS-1:0] hold_o
);
  logic [RES_BITS-1:0] pend_q, hold_q;
  logic                pend_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else if (line_start_i) begin
      pend_v_q <= 1'b0;
    end else if (res_valid_i) begin
      pend_q   <= res_data_i;
      pend_v_q <= 1'b1;
    end else if (load_i) begin
      pend_v_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_q <= '0;
    else if (load_i) hold_q <= pend_q;
  end

  assign pend_v_o = pend_v_q;
  assign hold_o   = hold_q;
endmodule

// File: rtl/adc_port_nibble_mux.sv
module adc_port_nibble_mux
  import adc_port_pkg::*;
#(
  parameter int unsigned RES_BITS = 12
) (
  input  logic [RES_BITS-1:0] word_i,
  input  phase_t              phase_i,
  output logic [BUS_W-1:0]    bus_o
);
  localparam int unsigned LO_W  = RES_BITS - BUS_W;
  localparam int unsigned PAD_W = BUS_W - LO_W;

  logic [BUS_W-1:0] hi_half, lo_half;

  assign hi_half = word_i[RES_BITS-1 -: BUS_W];

  generate
    if (PAD_W == 0) begin : g_full
      assign lo_half = word_i[BUS_W-1:0];
    end else begin : g_pad
      // lower half left-justified, zero fill
      assign lo_half = {word_i[LO_W-1:0], {PAD_W{1'b0}}};
    end
  endgenerate

  assign bus_o = phase_i[PH_W-1] ? lo_half : hi_half;
endmodule

// File: rtl/adc_nibble_port.sv
module adc_nibble_port
  import adc_port_pkg::*;
#(
  parameter int unsigned RES_BITS = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                line_start_i,
  input  logic                res_valid_i,
  input  logic [RES_BITS-1:0] res_data_i,
  output logic [5:0]          bus_o,
  output logic [5:0]          bus_oe_o
);
  phase_t              phase_q;
  logic                busy_q;
  logic                load;
  logic                pend_v;
  logic [RES_BITS-1:0] hold_q;
  logic                oe_q;

  adc_port_phase_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_start_i (line_start_i),
    .pend_v_i     (pend_v),
    .phase_o      (phase_q),
    .busy_o       (busy_q),
    .load_o       (load)
  );

  adc_port_result_hold #(.RES_BITS(RES_BITS)) u_hold (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_start_i (line_start_i),
    .res_valid_i  (res_valid_i),
    .res_data_i   (res_data_i),
    .load_i       (load),
    .pend_v_o     (pend_v),
    .hold_o       (hold_q)
  );

  adc_port_nibble_mux #(.RES_BITS(RES_BITS)) u_mux (
    .word_i  (hold_q),
    .phase_i (phase_q),
    .bus_o   (bus_o)
  );

  // released on the same edge line-start is seen
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else         oe_q <= !line_start_i;
  end

  assign bus_oe_o = {BUS_W{oe_q}};
endmodule

// File: rtl/adc_nibble_port_chk.sv
module adc_nibble_port_chk
  import adc_port_pkg::*;
#(
  parameter int unsigned RES_BITS = 12
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                line_start_i,
  input logic [5:0]          bus_o,
  input logic [5:0]          bus_oe_o,
  input phase_t              phase_q,
  input logic                busy_q,
  input logic [RES_BITS-1:0] hold_q
);
  a_r5_oe_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i |=> bus_oe_o == 6'h00);

  a_r5_oe_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_start_i |=> bus_oe_o == 6'h3f);

  a_r2_phase_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && phase_q != PH_LAST && !line_start_i |=> phase_q == phase_t'($past(phase_q) + 2'd1));

  a_r2_pair_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !phase_q[0] && !line_start_i |=> $stable(bus_o));

  a_r7_hold_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && phase_q != PH_LAST |=> $stable(hold_q));

  a_r9_phase_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i |=> phase_q == '0 && !busy_q);

  generate
    if (RES_BITS == 10) begin : g_r4
      a_r4_zero_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phase_q[1] |-> bus_o[1:0] == 2'b00);
    end
  endgenerate
endmodule

bind adc_nibble_port adc_nibble_port_chk #(.RES_BITS(RES_BITS)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .line_start_i (line_start_i),
  .bus_o        (bus_o),
  .bus_oe_o     (bus_oe_o),
  .phase_q      (phase_q),
  .busy_q       (busy_q),
  .hold_q       (hold_q)
);

// File: tb/adc_nibble_port_tb_top.sv
module adc_nibble_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ls = 1'b0;
  logic        vld = 1'b0;
  logic [11:0] dat = '0;
  logic [5:0]  bus12, oe12, bus10, oe10;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_nibble_port #(.RES_BITS(12)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .line_start_i(ls), .res_valid_i(vld),
    .res_data_i(dat), .bus_o(bus12), .bus_oe_o(oe12)
  );

  adc_nibble_port #(.RES_BITS(10)) dut10_i (
    .clk_i(clk), .rst_ni(rst_n), .line_start_i(ls), .res_valid_i(vld),
    .res_data_i(dat[9:0]), .bus_o(bus10), .bus_oe_o(oe10)
  );

  function automatic logic [5:0] exp12(logic [11:0] v, int ph);
    return (ph >= 2) ? 6'(v % 64) : 6'(v / 64);
  endfunction

  function automatic logic [5:0] exp10(logic [11:0] v, int ph);
    return (ph >= 2) ? 6'((v % 16) * 4) : 6'((v % 1024) / 16);
  endfunction

  task automatic chk(string req, logic [5:0] got, logic [5:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // check both variants for word v at phase ph
  task automatic chk_word(string req, logic [11:0] v, int ph);
    chk({req, "/R3"}, bus12, exp12(v, ph));
    chk({req, "/R4"}, bus10, exp10(v, ph));
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    logic [11:0] a, b, last;
    tick();
    // R1: reset state
    chk("R1 oe12", oe12, 6'h00);
    chk("R1 oe10", oe10, 6'h00);
    chk("R1 bus", bus12, 6'h00);
    rst_n = 1'b1;
    tick();
    chk("R5 oe on", oe12, 6'h3f);

    // R6/R8 streaming sweep of all 12-bit values
    dat = 12'h000; vld = 1'b1; tick(); vld = 1'b0;
    for (int i = 0; i < 4096; i++) begin
      logic [11:0] v;
      v = 12'(i);
      for (int ph = 0; ph < 4; ph++) begin
        tick();
        chk_word((ph == 0) ? "R6/R8" : "R2", v, ph);
        if (ph == 2 && i < 4095) begin dat = 12'(i + 1); vld = 1'b1; end
        if (ph == 3) vld = 1'b0;
      end
    end
    last = 12'hfff;

    // R10 idle: no pending result
    for (int k = 0; k < 3; k++) begin
      tick();
      chk_word("R10", last, 0);
      chk("R10 oe", oe12, 6'h3f);
    end

    // R7 early arrival
    a = 12'ha5c; b = 12'h3e7;
    dat = a; vld = 1'b1; tick(); vld = 1'b0;
    tick(); chk_word("R6", a, 0);
    dat = b; vld = 1'b1;
    tick(); vld = 1'b0; chk_word("R7", a, 1);
    tick(); chk_word("R7", a, 2);
    tick(); chk_word("R7", a, 3);
    tick(); chk_word("R7 next", b, 0);
    tick(); chk_word("R7 next", b, 1);
    tick(); chk_word("R7 next", b, 2);
    tick(); chk_word("R7 next", b, 3);
    tick(); chk_word("R10", b, 0);

    // R9 line-start abort mid-sequence, strobes ignored
    dat = a; vld = 1'b1; tick(); vld = 1'b0;
    tick(); chk_word("R9 pre", a, 0);
    tick(); chk_word("R9 pre", a, 1);
    dat = b; vld = 1'b1; ls = 1'b1;
    tick();
    chk("R5 oe12 off", oe12, 6'h00);
    chk("R5 oe10 off", oe10, 6'h00);
    chk_word("R9 phase0", a, 0);
    dat = 12'h123;
    tick(); vld = 1'b0;
    tick(); ls = 1'b0;
    tick();
    chk("R5 oe back", oe12, 6'h3f);
    for (int k = 0; k < 4; k++) begin
      tick();
      chk_word("R9 discard", a, 0);
    end

    // R5 single-cycle line-start pulse
    ls = 1'b1; tick(); ls = 1'b0;
    chk("R5 pulse off", oe10, 6'h00);
    tick(); chk("R5 pulse on", oe10, 6'h3f);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule